// File: doc/BRIEF.md
# Bit-serial clock synthesizer loader

This block programs an external frequency synthesizer over a two-wire serial path made of a data line and a clock line. A separate strobe latches each new pair of line levels into the synthesizer. When `start` is seen while the block is idle, it captures a 5-bit location address and a 13-bit program word. It then plays out a fixed sequence of strobed phases, pulses `done_o` and returns to idle. Software or a higher-level sequencer supplies the program word. This block only handles the wire protocol and the settle timing.

Each strobe is preceded by a settle window of `SETTLE_CYC` system-clock cycles, during which the line levels are held. The default of 3250 cycles gives about 26 µs at 125 MHz. The sequence has three parts. First come two preamble strobes with all lines low: one with the select line low and one with it high. Next comes a 21-bit frame, sent least significant bit first. The frame holds a header of 1, 0, 0, then the location, then the program word. Every frame bit costs two strobed phases: one with the serial clock low and one with it high.

The controller is a Moore state machine with these states:
- IDLE
- PRE_LO_WAIT → PRE_LO_STB
- PRE_HI_WAIT → PRE_HI_STB
- BIT_LO_WAIT → BIT_LO_STB → BIT_HI_WAIT → BIT_HI_STB, which loops back to BIT_LO_WAIT until the last frame bit
- DONE → IDLE

A WAIT state moves to its STB state when the settle timer expires. An STB state always moves on after a single cycle. IDLE leaves only on `start`.

Top module: `clkser_loader`

## Requirements
- R1: While reset is asserted, and after it until a start, `ser_data_o`, `ser_clk_o`, `sel_o`, `strobe_o` and `done_o` are all 0.
- R2: Location and program word are captured on the clock edge where `start` is high in IDLE. Later changes to `loc_i` and `prog_i`, and further `start` pulses, have no effect until the frame ends.
- R3: With the accepting edge as cycle reference and the next cycle numbered 0, strobe k (k = 0..43) is high in cycle k*(SETTLE_CYC+1)+SETTLE_CYC only. Each strobe is one cycle wide, and the line levels do not change in the cycle before it.
- R4: Strobe 0 is issued with select, data and clock all 0. Strobe 1 is issued with select 1 and data and clock 0.
- R5: The first three frame bits are 1, 0, 0 in that order. The last 0 selects a write. Select stays 1 throughout all bit phases.
- R6: The next five frame bits are `loc_i[0]` through `loc_i[4]`.
- R7: The last thirteen frame bits are `prog_i[0]` through `prog_i[12]`.
- R8: Frame bit j is sent as strobe 2+2j with the clock 0 and strobe 3+2j with the clock 1, with data equal to the bit in both. Data never changes while the clock is high.
- R9: `done_o` is high for exactly one cycle, cycle 44*(SETTLE_CYC+1), after 44 strobes. In that cycle data, clock, select and strobe are 0, and in the following cycle all outputs are 0.
- R10: A start given in the first idle cycle after `done_o` begins a new frame that meets R3 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame, honoured only in IDLE |
| loc_i | input | LOC_W (5) | Location address to send |
| prog_i | input | PROG_W (13) | Program word to send |
| ser_data_o | output | 1 | Serial data line |
| ser_clk_o | output | 1 | Serial clock line |
| sel_o | output | 1 | Select line, low in the first preamble phase and high after it |
| strobe_o | output | 1 | One-cycle latch pulse at the end of each settle window |
| done_o | output | 1 | One-cycle pulse after the final strobe |

## Verification
All outputs decode combinationally from registered state, so each result is due in a fixed cycle. Counted from the first cycle after the accepting edge, strobe k is due in cycle k*(SETTLE_CYC+1)+SETTLE_CYC and `done_o` in cycle 44*(SETTLE_CYC+1). The bench drives inputs on the falling edge and samples on the falling edge, one cycle at a time. It keeps a cycle index from the accepting edge and compares each strobe's index and line levels with a frame it builds from the captured inputs. It does the same for the done cycle and for the idle cycle that follows. Random frames, some disturbed by mid-frame input changes and extra start pulses, are mixed with directed all-zero, all-one and alternating patterns and with back-to-back starts.

// File: rtl/clkser_pkg.sv
package clkser_pkg;

    localparam int unsigned HDR_W = 3;
    // Header sent LSB first: 1 then 0 then 0 (the last 0 selects a write).
    localparam logic [HDR_W-1:0] HDR_BITS = 3'b001;
    // Two preamble strobes precede the two strobes of each frame bit.
    localparam int unsigned PRE_STROBES = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE_LO_WAIT,
        ST_PRE_LO_STB,
        ST_PRE_HI_WAIT,
        ST_PRE_HI_STB,
        ST_BIT_LO_WAIT,
        ST_BIT_LO_STB,
        ST_BIT_HI_WAIT,
        ST_BIT_HI_STB,
        ST_DONE
    } ld_state_t;

    function automatic logic is_settle(ld_state_t s);
        return (s == ST_PRE_LO_WAIT) || (s == ST_PRE_HI_WAIT) ||
               (s == ST_BIT_LO_WAIT) || (s == ST_BIT_HI_WAIT);
    endfunction

endpackage

// File: rtl/clkser_settle.sv
module clkser_settle #(
    parameter int unsigned SETTLE_CYC = 3250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);

    generate
        if (SETTLE_CYC <= 1) begin : g_single
            // A one-cycle window: the strobe follows right after one held cycle.
            assign expired_o = 1'b1;
        end else begin : g_count
            localparam int unsigned CNT_W = $clog2(SETTLE_CYC);
            localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYC - 1);

            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (load_i) begin
                    cnt_q <= RELOAD;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            assign expired_o = (cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/clkser_frame.sv
module clkser_frame #(
    parameter int unsigned FRAME_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               advance_i,
    output logic               bit_o,
    output logic               last_o
);

    localparam int unsigned IDX_W = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shift_q;
    logic [IDX_W-1:0]   idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            idx_q   <= '0;
        end else if (load_i) begin
            shift_q <= frame_i;
            idx_q   <= '0;
        end else if (advance_i) begin
            shift_q <= {1'b0, shift_q[FRAME_W-1:1]};
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign bit_o  = shift_q[0];
    assign last_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/clkser_loader.sv
module clkser_loader
    import clkser_pkg::*;
#(
    parameter int unsigned LOC_W      = 5,
    parameter int unsigned PROG_W     = 13,
    parameter int unsigned SETTLE_CYC = 3250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LOC_W-1:0]  loc_i,
    input  logic [PROG_W-1:0] prog_i,
    output logic              ser_data_o,
    output logic              ser_clk_o,
    output logic              sel_o,
    output logic              strobe_o,
    output logic              done_o
);

    localparam int unsigned FRAME_W = HDR_W + LOC_W + PROG_W;

    ld_state_t state_q;
    ld_state_t state_d;

    logic tmr_load;
    logic tmr_expired;
    logic frm_load;
    logic frm_advance;
    logic frm_bit;
    logic frm_last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start) state_d = ST_PRE_LO_WAIT;
            ST_PRE_LO_WAIT: if (tmr_expired) state_d = ST_PRE_LO_STB;
            ST_PRE_LO_STB:  state_d = ST_PRE_HI_WAIT;
            ST_PRE_HI_WAIT: if (tmr_expired) state_d = ST_PRE_HI_STB;
            ST_PRE_HI_STB:  state_d = ST_BIT_LO_WAIT;
            ST_BIT_LO_WAIT: if (tmr_expired) state_d = ST_BIT_LO_STB;
            ST_BIT_LO_STB:  state_d = ST_BIT_HI_WAIT;
            ST_BIT_HI_WAIT: if (tmr_expired) state_d = ST_BIT_HI_STB;
            ST_BIT_HI_STB:  state_d = frm_last ? ST_DONE : ST_BIT_LO_WAIT;
            ST_DONE:        state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // Timer reload on entry to any settle window; frame capture only from IDLE.
    assign tmr_load    = is_settle(state_d) && !is_settle(state_q);
    assign frm_load    = (state_q == ST_IDLE) && start;
    assign frm_advance = (state_q == ST_BIT_HI_STB) && !frm_last;

    // Output decode
    always_comb begin
        ser_data_o = 1'b0;
        ser_clk_o  = 1'b0;
        sel_o      = 1'b0;
        strobe_o   = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PRE_LO_WAIT: ;
            ST_PRE_LO_STB: strobe_o = 1'b1;
            ST_PRE_HI_WAIT: sel_o = 1'b1;
            ST_PRE_HI_STB: begin
                sel_o    = 1'b1;
                strobe_o = 1'b1;
            end
            ST_BIT_LO_WAIT: begin
                sel_o      = 1'b1;
                ser_data_o = frm_bit;
            end
            ST_BIT_LO_STB: begin
                sel_o      = 1'b1;
                ser_data_o = frm_bit;
                strobe_o   = 1'b1;
            end
            ST_BIT_HI_WAIT: begin
                sel_o      = 1'b1;
                ser_data_o = frm_bit;
                ser_clk_o  = 1'b1;
            end
            ST_BIT_HI_STB: begin
                sel_o      = 1'b1;
                ser_data_o = frm_bit;
                ser_clk_o  = 1'b1;
                strobe_o   = 1'b1;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    clkser_settle #(
        .SETTLE_CYC (SETTLE_CYC)
    ) settle_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    clkser_frame #(
        .FRAME_W (FRAME_W)
    ) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (frm_load),
        .frame_i   ({prog_i, loc_i, HDR_BITS}),
        .advance_i (frm_advance),
        .bit_o     (frm_bit),
        .last_o    (frm_last)
    );

endmodule

// File: rtl/clkser_loader_chk.sv
module clkser_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_data_o,
    input logic ser_clk_o,
    input logic sel_o,
    input logic strobe_o,
    input logic done_o
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o); // R3

    AST_LEVELS_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> ($stable(ser_data_o) && $stable(ser_clk_o) && $stable(sel_o))); // R3

    AST_CLK_RISE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> $past(strobe_o)); // R8

    AST_DATA_HELD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o)); // R8

    AST_SEL_IN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk_o |-> sel_o); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !strobe_o)); // R9

    AST_DONE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ser_clk_o && !ser_data_o && !sel_o && !strobe_o)); // R9

endmodule

bind clkser_loader clkser_loader_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_data_o (ser_data_o),
    .ser_clk_o  (ser_clk_o),
    .sel_o      (sel_o),
    .strobe_o   (strobe_o),
    .done_o     (done_o)
);

// File: tb/clkser_loader_tb_top.sv
module clkser_loader_tb_top;

    localparam int S       = 3;
    localparam int LW      = 5;
    localparam int PW      = 13;
    localparam int FW      = 3 + LW + PW;
    localparam int NSTB    = 2 + 2 * FW;
    localparam int DONE_AT = NSTB * (S + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] loc = '0;
    logic [PW-1:0] prog = '0;
    logic          sdata, sclk, sel, strobe, done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    clkser_loader #(
        .LOC_W      (LW),
        .PROG_W     (PW),
        .SETTLE_CYC (S)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .loc_i      (loc),
        .prog_i     (prog),
        .ser_data_o (sdata),
        .ser_clk_o  (sclk),
        .sel_o      (sel),
        .strobe_o   (strobe),
        .done_o     (done)
    );

    function automatic logic [FW-1:0] exp_frame(logic [LW-1:0] l, logic [PW-1:0] p);
        return {p, l, 3'b001};
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all_low(string tag);
        chk({sdata, sclk, sel, strobe, done} == 5'b0, tag, "all outputs low",
            int'({sdata, sclk, sel, strobe, done}), 0);
    endtask

    // Called at a falling edge; leaves at the falling edge on which done is seen.
    task automatic run_frame(logic [LW-1:0] l, logic [PW-1:0] p, bit disturb);
        logic [FW-1:0] fr = exp_frame(l, p);
        int  k = 0;
        bit  seen = 1'b0;
        loc = l; prog = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n <= DONE_AT + 4 && !seen; n++) begin
            if (strobe) begin
                chk(n == k * (S + 1) + S, "R3", "strobe cycle", n, k * (S + 1) + S);
                if (k < NSTB) begin
                    logic es, ed, ec;
                    string tg;
                    if (k < 2) begin
                        es = (k == 1); ed = 1'b0; ec = 1'b0; tg = "R4";
                    end else begin
                        int j = (k - 2) / 2;
                        es = 1'b1; ec = ((k - 2) % 2) == 1; ed = fr[j];
                        tg = (j < 3) ? "R5" : (j < 8) ? "R6" : "R7";
                    end
                    chk(sdata == ed, tg, "data at strobe", int'(sdata), int'(ed));
                    chk(sclk == ec, (k < 2) ? "R4" : "R8", "clock at strobe", int'(sclk), int'(ec));
                    chk(sel == es, (k < 2) ? "R4" : "R5", "select at strobe", int'(sel), int'(es));
                end
                k++;
            end
            if (done) begin
                chk(n == DONE_AT, "R9", "done cycle", n, DONE_AT);
                chk(k == NSTB, "R9", "strobe count", k, NSTB);
                chk({sclk, sdata, sel} == 3'b0, "R9", "lines at done", int'({sclk, sdata, sel}), 0);
                seen = 1'b1;
            end
            if (!seen) begin
                // R2: mid-frame input changes and a second start must be ignored
                if (disturb && n == 5) begin
                    start = 1'b1; loc = ~l; prog = ~p;
                end
                if (disturb && n == 6) start = 1'b0;
                if (disturb && n == 90) begin
                    start = 1'b1; loc = l ^ 5'h0f;
                end
                if (disturb && n == 91) start = 1'b0;
                @(negedge clk);
            end
        end
        chk(seen, "R9", "done observed", int'(seen), 1);
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk_all_low("R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int e0;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk_all_low("R1");
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk_all_low("R1");
        end

        // Directed patterns
        run_frame(5'h00, 13'h0000, 1'b0); idle_check();
        run_frame(5'h1f, 13'h1fff, 1'b0); idle_check();
        run_frame(5'h15, 13'h0aaa, 1'b1); idle_check();
        run_frame(5'h0a, 13'h1555, 1'b0); idle_check();
        run_frame(5'h01, 13'h1000, 1'b1); idle_check();

        // R10: start on the first idle cycle after done
        e0 = errors;
        run_frame(5'h12, 13'h0c3d, 1'b0);
        idle_check();
        run_frame(5'h09, 13'h13a6, 1'b0);
        chk(errors == e0, "R10", "back-to-back frame failures", errors - e0, 0);
        idle_check();

        // Random frames
        for (int i = 0; i < 12; i++) begin
            logic [LW-1:0] rl = LW'($urandom);
            logic [PW-1:0] rp = PW'($urandom);
            run_frame(rl, rp, ($urandom % 3) == 0);
            idle_check();
            repeat ($urandom % 4) begin
                @(negedge clk);
                chk(!strobe && !done, "R2", "no activity without start",
                    int'({strobe, done}), 0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule